// File: doc/BRIEF.md
# Memory Encryption Activation Register

This block is a write-once control register that switches on memory encryption. A configuration bus writes a 64-bit word with a one-cycle strobe. The word is checked against a capability word supplied on an input. A word that breaks a rule is dropped, leaves every bit of state as it was, and produces a one-cycle general-fault pulse.

A legal word that leaves encryption off is committed at once and locked. A legal word that turns encryption on starts a request/acknowledge exchange with an external key source. Bit 2 of the word tells that source to create a fresh key or restore a stored one. The register reports busy until the acknowledge arrives. The pass/fail flag that comes with the acknowledge decides what is stored and which low bits read back.

The lock output freezes this register. Sibling range registers can use the same output to freeze themselves. Only reset releases the lock.

Top module: `enc_activate_reg`

## Requirements
- R1: After reset, rd_data is zero, and locked, busy, key_req and gp_fault are all low.
- R2: A rejected write raises gp_fault for exactly one cycle, in the cycle after the strobe, and leaves rd_data unchanged.
- R3: Any write while the lock bit (bit 0) is 1 is rejected. Only reset clears the lock.
- R4: A write with any bit set in the reserved ranges 30:8 or 47:36 is rejected. So is a write with bit 49 set or any of bits 63:51 set.
- R5: The policy field is bits 7:4. It selects a bit of cap_word: bit 0 means 128-bit XTS (policy 0000) and bit 2 means 256-bit XTS (policy 0010). A write whose selected capability bit is 0 is rejected.
- R6: The key-ID count is bits 35:32. A write is rejected if the count exceeds cap_word[35:32]. It is also rejected if the count is nonzero while the enable bit (bit 1) is 0.
- R7: An accepted write with enable=0 is stored in the next cycle with bit 0 forced to 1 (low bits read ...01). No key request is made.
- R8: An accepted write with enable=1 raises key_req and busy in the next cycle, with key_restore equal to written bit 2. Both are held, and key_restore stays stable, until key_ack is seen.
- R9: An acknowledge with key_pass=1 stores the written word with bits 1:0 set. The low bits read ...011 for a new key and ...111 for a restored key, and the register is locked.
- R10: An acknowledge with key_pass=0 and a key-ID count of zero stores the written word with bits 1:0 cleared. The low bits read ...000 or ...100, and the register stays unlocked for a later write.
- R11: An acknowledge with key_pass=0 and a nonzero key-ID count commits nothing, so rd_data keeps its earlier value.
- R12: A write that arrives while busy is rejected, and rd_data does not change until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 64 | Word to write |
| cap_word | input | 64 | Capability word: algorithm support bits and maximum key-ID count |
| key_req | output | 1 | Request to the key source |
| key_restore | output | 1 | 1 = restore a stored key, 0 = create a new key |
| key_ack | input | 1 | One-cycle acknowledge from the key source |
| key_pass | input | 1 | Result flag that comes with key_ack |
| rd_data | output | 64 | Register contents |
| locked | output | 1 | Lock bit, drives the sibling range registers |
| busy | output | 1 | A key request is outstanding |
| gp_fault | output | 1 | One-cycle pulse on a rejected write |

## Verification
The hardest case to reach is a failed key exchange for a word with a nonzero key-ID count, because it must leave behind contents that an earlier write stored. The stimulus first lets a key-ID-free write fail, which stores a distinctive unlocked word. It then fails a second write that carries a key-ID count and checks that the first word survives. A write sent during the open handshake covers the busy rejection. The bench checks that the request stays up and that the stored value stays frozen until the modelled key source answers.

// File: rtl/enc_act_pkg.sv
package enc_act_pkg;
  localparam int DATA_W   = 64;
  localparam int LOCK_B   = 0;
  localparam int EN_B     = 1;
  localparam int KSEL_B   = 2;
  localparam int POL_LO   = 4;
  localparam int POL_W    = 4;
  localparam int KID_LO   = 32;
  localparam int KID_W    = 4;
  localparam int ALG_LO   = 48;

  // Bits that must be zero in a written word.
  function automatic logic [DATA_W-1:0] rsvd_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if ((i >= POL_LO + POL_W && i <= 30) ||
          (i >= KID_LO + KID_W && i < ALG_LO) ||
          (i == ALG_LO + 1) || (i >= ALG_LO + 3))
        m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/enc_act_check.sv
module enc_act_check
  import enc_act_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cap,
  input  logic              is_locked,
  input  logic              is_busy,
  output logic              reject,
  output logic              need_key
);
  localparam logic [DATA_W-1:0] RSVD = rsvd_mask();

  logic [POL_W-1:0] pol;
  logic [KID_W-1:0] kid;
  logic [KID_W-1:0] kid_max;
  logic             rsvd_hit, pol_bad, kid_bad;

  always_comb begin
    pol      = wdata[POL_LO +: POL_W];
    kid      = wdata[KID_LO +: KID_W];
    kid_max  = cap[KID_LO +: KID_W];
    rsvd_hit = |(wdata & RSVD);
    pol_bad  = ~cap[pol];
    kid_bad  = (kid > kid_max) || ((kid != '0) && !wdata[EN_B]);
    reject   = is_locked | is_busy | rsvd_hit | pol_bad | kid_bad;
    need_key = wdata[EN_B];
  end
endmodule

// File: rtl/enc_act_keyhs.sv
module enc_act_keyhs (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sel,
  input  logic ack,
  input  logic pass,
  output logic req,
  output logic req_sel,
  output logic done,
  output logic done_pass
);
  logic req_q, sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (req_q) begin
      if (ack) req_q <= 1'b0;
    end else if (start) begin
      req_q <= 1'b1;
      sel_q <= sel;
    end
  end

  assign req       = req_q;
  assign req_sel   = sel_q;
  assign done      = req_q & ack;
  assign done_pass = pass;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack) |=> req_q); // R8
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack) |=> $stable(sel_q)); // R8
endmodule

// File: rtl/enc_activate_reg.sv
module enc_activate_reg
  import enc_act_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cap_word,
  output logic              key_req,
  output logic              key_restore,
  input  logic              key_ack,
  input  logic              key_pass,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked,
  output logic              busy,
  output logic              gp_fault
);
  localparam logic [DATA_W-1:0] LOW2 = DATA_W'(3);

  logic [DATA_W-1:0] reg_q, pend_q;
  logic              gp_q;
  logic              reject, need_key, start, done, done_pass;

  enc_act_check u_check (
    .wdata    (wr_data),
    .cap      (cap_word),
    .is_locked(reg_q[LOCK_B]),
    .is_busy  (key_req),
    .reject   (reject),
    .need_key (need_key)
  );

  assign start = wr_en & ~reject & need_key;

  enc_act_keyhs u_hs (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sel      (wr_data[KSEL_B]),
    .ack      (key_ack),
    .pass     (key_pass),
    .req      (key_req),
    .req_sel  (key_restore),
    .done     (done),
    .done_pass(done_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= '0;
      pend_q <= '0;
      gp_q   <= 1'b0;
    end else begin
      gp_q <= 1'b0;
      if (wr_en) begin
        if (reject)
          gp_q <= 1'b1;
        else if (!need_key)
          reg_q <= {wr_data[DATA_W-1:1], 1'b1};
        else
          pend_q <= wr_data;
      end
      if (done) begin
        if (done_pass)
          reg_q <= pend_q | LOW2;
        else if (pend_q[KID_LO +: KID_W] == '0)
          reg_q <= pend_q & ~LOW2;
      end
    end
  end

  assign rd_data  = reg_q;
  assign locked   = reg_q[LOCK_B];
  assign busy     = key_req;
  assign gp_fault = gp_q;

  AST_FAULT_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
    gp_q |-> $stable(reg_q)); // R2
  AST_FAULT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    gp_q |-> $past(wr_en)); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    reg_q[LOCK_B] |=> reg_q[LOCK_B]); // R3
  AST_EN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    reg_q[EN_B] |-> reg_q[LOCK_B]); // R9
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (key_req && !key_ack) |=> $stable(reg_q)); // R12
endmodule

// File: tb/enc_activate_reg_test.sv
module enc_activate_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] cap_word = 64'h0000_0004_0000_0005;
  logic        key_req, key_restore, locked, busy, gp_fault;
  logic        key_ack = 1'b0, key_pass = 1'b0;
  logic [63:0] rd_data;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  enc_activate_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cap_word(cap_word),
    .key_req(key_req), .key_restore(key_restore), .key_ack(key_ack), .key_pass(key_pass),
    .rd_data(rd_data), .locked(locked), .busy(busy), .gp_fault(gp_fault)
  );

  localparam int NV = 14;
  // response: 0 none, 1 pass, 2 fail
  localparam logic [63:0] VW [NV] = '{
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0100, 64'h0000_0100_0000_0000,
    64'h0002_0000_0000_0000, 64'h0000_0000_0000_0012, 64'h0000_0000_0000_0032,
    64'h0000_0005_0000_0002, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0002,
    64'h0000_0000_0000_0026, 64'h0001_0000_8000_0002, 64'h0000_0000_0000_0006,
    64'h0000_0004_0000_0002, 64'h0005_0004_0000_002A};
  localparam logic [1:0] VK [NV] = '{0,0,0,0,0,0,0,0,1,1,2,2,2,1};
  localparam logic VF [NV] = '{0,1,1,1,1,1,1,1,0,0,0,0,0,0};
  localparam logic [63:0] VR [NV] = '{
    64'h1, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h3, 64'h27,
    64'h0001_0000_8000_0000, 64'h4, 64'h0, 64'h0005_0004_0000_002B};
  localparam string VT [NV] = '{"R7","R4","R4","R4","R5","R5","R6","R6",
                                "R9","R9","R10","R10","R11","R9"};

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; key_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic respond(input logic p);
    @(negedge clk); key_ack = 1'b1; key_pass = p;
    @(negedge clk); key_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(rd_data == 64'h0, "R1", rd_data, 64'h0);
    chk({locked, busy, key_req, gp_fault} == 4'b0, "R1",
        {60'h0, locked, busy, key_req, gp_fault}, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      do_write(VW[i]);
      chk(gp_fault == VF[i], VT[i], {63'h0, gp_fault}, {63'h0, VF[i]});
      chk(key_req == (VK[i] != 0), VT[i], {63'h0, key_req}, {63'h0, VK[i] != 0});
      if (VK[i] != 0) respond(VK[i] == 2'd1);
      chk(rd_data == VR[i], VT[i], rd_data, VR[i]);
    end

    // R2: fault pulse lasts one cycle
    do_reset();
    do_write(64'h0000_0000_0000_0100);
    chk(gp_fault == 1'b1, "R2", {63'h0, gp_fault}, 64'h1);
    @(negedge clk);
    chk(gp_fault == 1'b0, "R2", {63'h0, gp_fault}, 64'h0);

    // R3: write after lock rejected
    do_reset();
    do_write(64'h0000_0000_8000_0000);
    chk(locked == 1'b1, "R7", {63'h0, locked}, 64'h1);
    do_write(64'h2);
    chk(gp_fault == 1'b1 && key_req == 1'b0, "R3", {62'h0, gp_fault, key_req}, 64'h2);
    chk(rd_data == 64'h0000_0000_8000_0001, "R3", rd_data, 64'h0000_0000_8000_0001);

    // R8: handshake held with restore select
    do_reset();
    do_write(64'h6);
    chk(key_req && busy && key_restore, "R8", {61'h0, key_req, busy, key_restore}, 64'h7);
    repeat (3) @(negedge clk);
    chk(key_req && busy && key_restore, "R8", {61'h0, key_req, busy, key_restore}, 64'h7);
    respond(1'b1);
    chk(!busy && rd_data == 64'h7, "R9", rd_data, 64'h7);

    // R12: write while busy rejected
    do_reset();
    do_write(64'h2);
    chk(key_restore == 1'b0, "R8", {63'h0, key_restore}, 64'h0);
    do_write(64'h0);
    chk(gp_fault && busy && rd_data == 64'h0, "R12", rd_data, 64'h0);
    respond(1'b1);
    chk(rd_data == 64'h3, "R12", rd_data, 64'h3);

    // R10 then R11: failure keeps earlier contents when key-ID count nonzero
    do_reset();
    do_write(64'h0000_0000_8000_0002);
    respond(1'b0);
    chk(rd_data == 64'h0000_0000_8000_0000 && !locked, "R10", rd_data, 64'h0000_0000_8000_0000);
    do_write(64'h0000_0002_0000_0026);
    chk(gp_fault == 1'b0 && key_req, "R11", {62'h0, gp_fault, key_req}, 64'h1);
    respond(1'b0);
    chk(rd_data == 64'h0000_0000_8000_0000, "R11", rd_data, 64'h0000_0000_8000_0000);
    do_write(64'h0000_0002_0000_0026);
    respond(1'b1);
    chk(rd_data == 64'h0000_0002_0000_0027, "R9", rd_data, 64'h0000_0002_0000_0027);

    // R5: 256-bit policy rejected when its capability bit is clear
    do_reset();
    cap_word = 64'h0000_0004_0000_0001;
    do_write(64'h22);
    chk(gp_fault == 1'b1 && rd_data == 64'h0, "R5", rd_data, 64'h0);
    cap_word = 64'h0000_0004_0000_0005;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule